// File: doc/BRIEF.md
# Entropy Pool Refill Sequencer

This block is the control sequencer for a true random number generator. Once it is enabled, it counts sample strobes from an external entropy source until a startup budget is met. It then raises an extract pulse, which tells the surrounding logic to move 64 bits from the pool into the output word, and one cycle later it sets a ready flag. Sampling then continues so the pool can be refilled. After a maximum refill budget has been collected, the block turns sampling off to save power.

Software consumes a word and then pulses a ready-clear input. A new word appears only after that clear. If enough refill samples were already gathered when the clear arrives, the next word appears straight away. If not, the block waits until the minimum refill budget has been collected. The three budgets use different units, and a zero in any of them selects the largest budget. All three are captured at the moment of enabling.

Top module: `rng_refill_seq`

## Requirements
- R1: During and after reset, and whenever enable is low, `ready_o`, `sampling_o` and `extract_o` are all 0.
- R2: After enable rises, the first extraction happens once `startup_cfg_i` × 256 strobes have been counted while sampling is active. `sampling_o` is 1 throughout the startup phase.
- R3: A startup or maximum-refill field of 0 selects a budget of 2^24 samples. With a startup field of 0, no word is ready after a few hundred strobes and sampling stays on.
- R4: After a clear, if the pool is short, the next extraction comes once `minref_cfg_i` × 64 strobes have been counted since the previous extraction. A field of 0 selects the maximum-refill budget. A minimum larger than the maximum is clamped to the maximum.
- R5: After each extraction, `sampling_o` stays 1 for exactly `maxref_cfg_i` × 256 strobes and then drops to 0. Strobes that arrive while sampling is off are not counted.
- R6: Once set, `ready_o` stays 1 until a cycle in which `rdy_clr_i` is 1, and it reads 0 on the next cycle. A clear while `ready_o` is 0 has no effect. No extraction occurs while `ready_o` is 1.
- R7: If the refill count already meets the minimum when a clear takes effect, `extract_o` is 1 in the cycle after the clear. `ready_o` is 1 again one cycle later, with no strobes needed.
- R8: Dropping enable returns the block to idle on the next cycle, clearing the ready flag and the sample count. Enable takes priority over a ready-clear in the same cycle.
- R9: The three configuration fields are captured in the cycle enable rises from idle. Changing them later has no effect until the next enable.
- R10: `extract_o` is a one-cycle pulse, and `ready_o` rises in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; low forces idle |
| strobe_i | input | 1 | One entropy sample taken this cycle |
| rdy_clr_i | input | 1 | Ready-clear pulse from software |
| startup_cfg_i | input | 16 | Startup budget, units of 256 samples, 0 = 2^24 |
| minref_cfg_i | input | 8 | Minimum refill, units of 64 samples, 0 = maximum refill |
| maxref_cfg_i | input | 16 | Maximum refill, units of 256 samples, 0 = 2^24 |
| ready_o | output | 1 | Output word valid |
| sampling_o | output | 1 | Entropy sampling active |
| extract_o | output | 1 | Move 64 bits from the pool to the output word |

## Verification
The hardest state to reach is the powered-down full pool: the maximum refill has been collected while a word is still unread. The instant-delivery path and the slow minimum-refill path can only be told apart from there. Each configuration row therefore drives the sequencer into that state by strobing until `sampling_o` falls. It then issues two back-to-back clears, so the first is served from the full pool and the second must wait for the minimum budget. Changing the configuration inputs just after enabling shows that the captured budgets are the ones in force.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

    localparam int COARSE_FW = 16;                      // startup / max refill field width
    localparam int FINE_FW   = 8;                       // min refill field width
    localparam int COARSE_SH = 8;                       // 256 samples per coarse unit
    localparam int FINE_SH   = 6;                       // 64 samples per fine unit
    localparam int CNT_W     = COARSE_FW + COARSE_SH + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t FULL_BUDGET = cnt_t'(1) << (COARSE_FW + COARSE_SH);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        cnt_t startup;
        cnt_t min_ref;
        cnt_t max_ref;
    } budget_t;

    function automatic cnt_t coarse_budget(input logic [COARSE_FW-1:0] f);
        if (f == '0) return FULL_BUDGET;
        return cnt_t'(f) << COARSE_SH;
    endfunction

    function automatic cnt_t fine_budget(input logic [FINE_FW-1:0] f, input cnt_t ceiling);
        cnt_t v;
        if (f == '0) return ceiling;
        v = cnt_t'(f) << FINE_SH;
        return (v > ceiling) ? ceiling : v;
    endfunction

endpackage

// File: rtl/rng_budget_dec.sv
module rng_budget_dec
    import rng_seq_pkg::*;
#(
    parameter bit CLAMP_MIN = 1'b1
) (
    input  logic [COARSE_FW-1:0] startup_f_i,
    input  logic [FINE_FW-1:0]   minref_f_i,
    input  logic [COARSE_FW-1:0] maxref_f_i,
    output budget_t              budget_o
);

    cnt_t max_b;

    always_comb begin
        max_b            = coarse_budget(maxref_f_i);
        budget_o.startup = coarse_budget(startup_f_i);
        budget_o.max_ref = max_b;
    end

    generate
        if (CLAMP_MIN) begin : g_clamp
            always_comb budget_o.min_ref = fine_budget(minref_f_i, max_b);
        end else begin : g_raw
            always_comb budget_o.min_ref = fine_budget(minref_f_i, FULL_BUDGET);
        end
    endgenerate

endmodule

// File: rtl/rng_sample_cnt.sv
module rng_sample_cnt
    import rng_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic inc_i,
    output cnt_t cnt_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != FULL_BUDGET)) begin
            cnt_o <= cnt_o + cnt_t'(1);
        end
    end

endmodule

// File: rtl/rng_seq_fsm.sv
module rng_seq_fsm
    import rng_seq_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    en_i,
    input  logic    clr_i,
    input  budget_t budget_i,
    input  cnt_t    cnt_i,
    output logic    ready_o,
    output logic    sampling_o,
    output logic    extract_o,
    output logic    cnt_clr_o
);

    seq_state_e state_q;
    budget_t    tgt_q;
    logic       ready_q;
    logic       fill_done;
    logic       pool_ok;
    logic       below_max;

    always_comb begin
        fill_done  = cnt_i >= tgt_q.startup;
        pool_ok    = cnt_i >= tgt_q.min_ref;
        below_max  = cnt_i <  tgt_q.max_ref;
        extract_o  = en_i && !ready_q &&
                     (((state_q == ST_FILL) && fill_done) ||
                      ((state_q == ST_RUN)  && pool_ok));
        sampling_o = en_i && ((state_q == ST_FILL) ||
                              ((state_q == ST_RUN) && below_max));
        cnt_clr_o  = !en_i || (state_q == ST_IDLE) || extract_o;
        ready_o    = ready_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
            tgt_q   <= '0;
        end else if (!en_i) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tgt_q   <= budget_i;
                    state_q <= ST_FILL;
                end
                ST_FILL: if (extract_o) state_q <= ST_RUN;
                default: state_q <= ST_RUN;
            endcase
            if (extract_o) begin
                ready_q <= 1'b1;
            end else if (clr_i) begin
                ready_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rng_refill_seq.sv
module rng_refill_seq
    import rng_seq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic                 strobe_i,
    input  logic                 rdy_clr_i,
    input  logic [COARSE_FW-1:0] startup_cfg_i,
    input  logic [FINE_FW-1:0]   minref_cfg_i,
    input  logic [COARSE_FW-1:0] maxref_cfg_i,
    output logic                 ready_o,
    output logic                 sampling_o,
    output logic                 extract_o
);

    budget_t budget;
    cnt_t    cnt;
    logic    cnt_clr;

    rng_budget_dec #(.CLAMP_MIN(1'b1)) dec_i (
        .startup_f_i (startup_cfg_i),
        .minref_f_i  (minref_cfg_i),
        .maxref_f_i  (maxref_cfg_i),
        .budget_o    (budget)
    );

    rng_seq_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .clr_i      (rdy_clr_i),
        .budget_i   (budget),
        .cnt_i      (cnt),
        .ready_o    (ready_o),
        .sampling_o (sampling_o),
        .extract_o  (extract_o),
        .cnt_clr_o  (cnt_clr)
    );

    rng_sample_cnt cnt_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (cnt_clr),
        .inc_i (strobe_i && sampling_o),
        .cnt_o (cnt)
    );

endmodule

// File: rtl/rng_refill_seq_chk.sv
module rng_refill_seq_chk (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic rdy_clr_i,
    input logic ready_o,
    input logic sampling_o,
    input logic extract_o
);

    AST_DISABLE_IDLES: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!ready_o && !sampling_o)); // R8

    AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && !rdy_clr_i && en_i) |=> ready_o); // R6

    AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && rdy_clr_i && en_i) |=> !ready_o); // R6

    AST_NO_EXTRACT_WHILE_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> !extract_o); // R6

    AST_EXTRACT_SETS_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        extract_o |=> ready_o); // R10

    AST_EXTRACT_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        extract_o |=> !extract_o); // R10

    AST_READY_FROM_EXTRACT: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> $past(extract_o)); // R10

endmodule

bind rng_refill_seq rng_refill_seq_chk chk_i (.*);

// File: tb/rng_refill_seq_tb_top.sv
module rng_refill_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        strobe = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] start_f = 16'd1;
    logic [7:0]  min_f = 8'd1;
    logic [15:0] max_f = 16'd1;
    logic        ready, active, extract;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    rng_refill_seq dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .en_i          (en),
        .strobe_i      (strobe),
        .rdy_clr_i     (clr),
        .startup_cfg_i (start_f),
        .minref_cfg_i  (min_f),
        .maxref_cfg_i  (max_f),
        .ready_o       (ready),
        .sampling_o    (active),
        .extract_o     (extract)
    );

    // rows: startup, min, max fields and expected startup / min-refill / max-refill sample counts
    localparam int NROW = 4;
    localparam int ROW_S[NROW]   = '{1, 2, 1, 1};
    localparam int ROW_MN[NROW]  = '{1, 3, 0, 20};
    localparam int ROW_MX[NROW]  = '{1, 2, 2, 1};
    localparam int EXP_S[NROW]   = '{256, 512, 256, 256};
    localparam int EXP_MN[NROW]  = '{64, 192, 512, 256};
    localparam int EXP_MX[NROW]  = '{256, 512, 512, 256};

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic strobe_once(output bit saw_ext);
        strobe = 1'b1;
        tick;
        saw_ext = extract;
        strobe = 1'b0;
        tick;
    endtask

    task automatic pulse_clr;
        clr = 1'b1;
        tick;
        clr = 1'b0;
    endtask

    task automatic run_row(input int r);
        int n;
        int got;
        bit e;
        start_f = 16'(ROW_S[r]);
        min_f   = 8'(ROW_MN[r]);
        max_f   = 16'(ROW_MX[r]);
        en = 1'b1;
        tick;
        // R9: later changes to the fields are not used
        start_f = 16'd7;
        min_f   = 8'd7;
        max_f   = 16'd7;
        chk_eq("R2", "sampling in startup", int'(active), 1);
        n = 0; got = 0;
        while (!ready && n < 6000) begin
            strobe_once(e);
            n++;
            if (e) got++;
        end
        chk_eq("R2", "startup samples", n, EXP_S[r]);
        chk_eq("R10", "extract pulses at startup", got, 1);
        n = 0; got = 0;
        while (active && n < 6000) begin
            strobe_once(e);
            n++;
            if (e) got++;
        end
        chk_eq("R5", "max refill samples", n, EXP_MX[r]);
        chk_eq("R6", "no extract while ready", got, 0);
        for (int k = 0; k < 5; k++) strobe_once(e);
        chk_eq("R5", "sampling stays off", int'(active), 0);
        chk_eq("R6", "ready held without clear", int'(ready), 1);
        pulse_clr;
        chk_eq("R6", "ready after clear", int'(ready), 0);
        chk_eq("R7", "immediate extract", int'(extract), 1);
        tick;
        chk_eq("R7", "ready again from full pool", int'(ready), 1);
        chk_eq("R5", "sampling resumes", int'(active), 1);
        pulse_clr;
        chk_eq("R4", "no extract on short pool", int'(extract), 0);
        n = 0;
        while (!ready && n < 6000) begin
            strobe_once(e);
            n++;
            if (n == 10) begin
                pulse_clr;   // R6: clear while not ready is ignored
            end
        end
        chk_eq("R4", "min refill samples", n, EXP_MN[r]);
        // R8: drop enable together with a clear
        en = 1'b0;
        clr = 1'b1;
        tick;
        clr = 1'b0;
        chk_eq("R8", "ready after disable", int'(ready), 0);
        chk_eq("R8", "sampling after disable", int'(active), 0);
        chk_eq("R1", "extract while disabled", int'(extract), 0);
        tick;
    endtask

    initial begin
        bit e;
        repeat (4) tick;
        chk_eq("R1", "ready in reset", int'(ready), 0);
        chk_eq("R1", "sampling in reset", int'(active), 0);
        chk_eq("R1", "extract in reset", int'(extract), 0);
        rst = 1'b0;
        tick;
        for (int k = 0; k < 20; k++) strobe_once(e);
        chk_eq("R1", "sampling while disabled", int'(active), 0);
        chk_eq("R1", "ready while disabled", int'(ready), 0);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R3: zero startup field means a 2^24 budget
        start_f = 16'd0;
        min_f = 8'd1;
        max_f = 16'd1;
        en = 1'b1;
        tick;
        for (int k = 0; k < 300; k++) strobe_once(e);
        chk_eq("R3", "no word with zero startup", int'(ready), 0);
        chk_eq("R3", "still sampling", int'(active), 1);
        // R8: enable drop alone resets the count; re-enable with startup 1 needs a full 256
        en = 1'b0;
        tick;
        start_f = 16'd1;
        en = 1'b1;
        tick;
        for (int k = 0; k < 255; k++) strobe_once(e);
        chk_eq("R8", "count restarted after disable", int'(ready), 0);
        strobe_once(e);
        chk_eq("R2", "word after 256th strobe", int'(ready), 1);
        en = 1'b0;
        tick;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule